// File: doc/BRIEF.md
# Mode-Dependent Bus Visibility Control

This block keeps one configuration bit that software may set exactly once after reset. What the bit does depends on the operating mode, which is captured while reset is held.

In the two modes that use an external bus, the bit turns on internal-read visibility. When it is on, every internal read cycle drives its data byte onto the external data bus, with the output enable asserted. In the two modes without an external bus, the same bit gates the E pin instead. A value of 0 lets the free-running E clock out on the pin. A value of 1 holds the pin low.

The reset value of the bit is 1 in the test mode and 0 in the other three modes. As a result, the E clock runs out of reset in every mode, and read visibility starts enabled only in the test mode.

Top module: `bus_vis_ctrl`

## Requirements
- R1: The mode (00 single-chip, 01 expanded, 10 bootstrap, 11 special test) is captured on every clock edge where `rst_n` is low. It is held after reset is released, so later changes on `mode_i` have no effect until the next reset.
- R2: At reset the control bit is 1 when the mode is 11 and 0 for modes 00, 01 and 10.
- R3: The first clock edge after reset with `cfg_wr_i` high loads `cfg_wdata_i` into the bit. Every later write until the next reset leaves the bit unchanged.
- R4: A write that is ignored under R3 raises `wr_drop_o` for exactly the one cycle after that write's clock edge. `wr_drop_o` is low at all other times.
- R5: In modes 01 and 11 with the bit at 1, `dbus_oe_o` equals `rd_int_i` and `dbus_o` equals `rd_data_i` while `dbus_oe_o` is high. With the bit at 0, `dbus_oe_o` stays low.
- R6: In modes 00 and 10, `epin_o` follows `eclk_i` when the bit is 0 and is held at 0 when the bit is 1.
- R7: In modes 01 and 11, `epin_o` always follows `eclk_i`.
- R8: In modes 00 and 10, `dbus_oe_o` stays low even during internal reads. Whenever `dbus_oe_o` is low, `dbus_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; mode is sampled while low |
| mode_i | input | 2 | Operating mode |
| cfg_wr_i | input | 1 | Write strobe for the control bit |
| cfg_wdata_i | input | 1 | Value to write |
| rd_int_i | input | 1 | Current cycle is an internal read |
| rd_data_i | input | 8 | Data byte of the internal read |
| eclk_i | input | 1 | Free-running E clock |
| epin_o | output | 1 | E pin level |
| dbus_oe_o | output | 1 | External data-bus output enable |
| dbus_o | output | 8 | External data-bus value |
| wr_drop_o | output | 1 | One-cycle flag for an ignored write |

## Verification
The assertions check the following on every cycle:
- the captured mode holds steady between resets;
- the bit takes its mode-dependent value out of reset and never changes after its single write;
- the bus enable never rises in the pin-gating modes, and otherwise only during internal reads carrying their own data;
- the E pin stays low whenever gating is selected;
- the drop flag only follows a write.

Only the bench's scenarios can show that the first write actually takes effect and that the correct meaning is applied in each of the four modes with both bit values. The reference model also confirms that a mode change after reset is ignored.

// File: rtl/bus_vis_ctrl.sv
module bus_vis_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic          cfg_wr_i,
  input  logic          cfg_wdata_i,
  input  logic          rd_int_i,
  input  logic [DW-1:0] rd_data_i,
  input  logic          eclk_i,
  output logic          epin_o,
  output logic          dbus_oe_o,
  output logic [DW-1:0] dbus_o,
  output logic          wr_drop_o
);

  localparam logic [1:0] MODE_TEST = 2'b11;

  logic [1:0] mode_q;
  logic       ctl_q;
  logic       used_q;
  logic       bus_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= mode_i;
      ctl_q     <= (mode_i == MODE_TEST);
      used_q    <= 1'b0;
      wr_drop_o <= 1'b0;
    end else begin
      wr_drop_o <= cfg_wr_i & used_q;
      if (cfg_wr_i && !used_q) begin
        ctl_q  <= cfg_wdata_i;
        used_q <= 1'b1;
      end
    end
  end

  assign bus_mode  = mode_q[0];
  assign epin_o    = eclk_i & (bus_mode | ~ctl_q);
  assign dbus_oe_o = bus_mode & ctl_q & rd_int_i;
  assign dbus_o    = dbus_oe_o ? rd_data_i : '0;

  p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(mode_q));

  p_reset_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!used_q && !$past(cfg_wr_i)) |-> (ctl_q == (mode_q == MODE_TEST)));

  p_write_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    used_q |=> $stable(ctl_q));

  p_drop_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop_o |-> $past(cfg_wr_i));

  p_oe_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dbus_oe_o |-> (rd_int_i && dbus_o == rd_data_i));

  p_epin_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_mode && ctl_q) |-> !epin_o);

  p_epin_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mode |-> (epin_o == eclk_i));

  p_no_oe_gating_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_mode |-> !dbus_oe_o);

endmodule

// File: tb/sim_bus_vis_ctrl.sv
`timescale 1ns/1ps
module sim_bus_vis_ctrl;
  logic clk = 0, rst_n = 0;
  logic [1:0] mode_i = 0;
  logic cfg_wr_i = 0, cfg_wdata_i = 0, rd_int_i = 0, eclk_i = 0;
  logic [7:0] rd_data_i = 0;
  logic epin_o, dbus_oe_o, wr_drop_o;
  logic [7:0] dbus_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  bit m_valid = 0;
  int m_mode = 0, m_bit = 0, m_done = 0, m_drop = 0;
  int stamp = 0;

  always #5 clk = ~clk;

  bus_vis_ctrl u0 (.clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cfg_wr_i(cfg_wr_i),
    .cfg_wdata_i(cfg_wdata_i), .rd_int_i(rd_int_i), .rd_data_i(rd_data_i),
    .eclk_i(eclk_i), .epin_o(epin_o), .dbus_oe_o(dbus_oe_o), .dbus_o(dbus_o),
    .wr_drop_o(wr_drop_o));

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s t=%0t got=%0d exp=%0d", tag, $time, got, exp);
    end
  endtask

  task automatic cyc(input bit rst, input int mode, input bit wr, input bit wd,
                     input bit rd, input string tag);
    bit vis; int e_ep, e_oe, e_db;
    @(negedge clk);
    rst_n = rst; mode_i = mode[1:0]; cfg_wr_i = wr; cfg_wdata_i = wd;
    rd_int_i = rd; stamp++; rd_data_i = 8'(stamp * 37 + 5); eclk_i = ~eclk_i;
    #1;
    if (m_valid && rst) begin
      vis = (m_mode == 1 || m_mode == 3);
      e_ep = vis ? int'(eclk_i) : (m_bit != 0 ? 0 : int'(eclk_i));
      e_oe = (vis && m_bit != 0 && rd) ? 1 : 0;
      e_db = e_oe != 0 ? int'(rd_data_i) : 0;
      chk(vis ? "R7 epin" : "R6 epin", int'(epin_o), e_ep);
      chk(vis ? "R5 oe" : "R8 oe", int'(dbus_oe_o), e_oe);
      chk("R8 R5 dbus", int'(dbus_o), e_db);
      chk("R4 drop", int'(wr_drop_o), m_drop);
      if (tag != "") begin
        chk({tag, " oe"}, int'(dbus_oe_o), e_oe);
        chk({tag, " epin"}, int'(epin_o), e_ep);
      end
    end
    @(posedge clk);
    if (!rst) begin
      m_valid = 1; m_mode = mode; m_bit = (mode == 3) ? 1 : 0; m_done = 0; m_drop = 0;
    end else begin
      m_drop = (wr && m_done != 0) ? 1 : 0;
      if (wr && m_done == 0) begin m_bit = wd; m_done = 1; end
    end
  endtask

  initial begin
    for (int m = 0; m < 4; m++) begin
      for (int wv = 0; wv < 2; wv++) begin
        cyc(0, m, 0, 0, 0, ""); cyc(0, m, 1, 1, 1, "");
        cyc(1, m, 0, 0, 1, "R2"); cyc(1, m, 0, 0, 0, "R2");
        cyc(1, m ^ 1, 0, 0, 1, "R1"); cyc(1, m ^ 2, 0, 0, 0, "R1");
        cyc(1, m, 1, wv[0], 0, ""); cyc(1, m, 0, 0, 1, "R3");
        cyc(1, m, 0, 0, 0, "R3");
        cyc(1, m, 1, ~wv[0], 1, ""); cyc(1, m, 0, 0, 1, "R3 R4");
        cyc(1, m, 1, ~wv[0], 0, ""); cyc(1, m, 1, wv[0], 1, "");
        cyc(1, m, 0, 0, 1, "R3"); cyc(1, m, 0, 0, 0, "R4");
        for (int k = 0; k < 6; k++) cyc(1, m, 0, 0, k[0], "");
      end
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule